// File: doc/BRIEF.md
# Parallel Flash Identifier Read Responder

This block answers identifier reads for a parallel NOR flash bank made of one or more identical devices placed side by side on a 32-bit data bus. The host writes a command byte. The value 0x90 switches the block into identifier mode. In that mode, a read at a byte address returns either the manufacturer code or the device code. The address decides which one. The value 0x98 selects the query mode. That mode belongs to a neighbouring responder, so this block drives zero while it is active. Any other command returns the block to array mode. In array mode the array data input is passed through untouched.

In identifier mode the byte address is first shifted right. The shift count comes from the bank width, the device's largest supported width and the width the device is actually wired at. This maps a narrow-wired device back onto its full-width identifier addresses. The answer of one device is then copied into every device lane of the bank word. A read wider than the bank is built from several bank-wide lookups at consecutive bank addresses. If the configured device width is zero, an older decode is used instead. It works on the low address byte and returns the identifier bytes packed in pairs.

Top module: `flash_id_responder`

## Requirements
- R1: A synchronous active-high reset puts the block in array mode, clears `rdData` to zero and holds `rdValid` low.
- R2: A command write of 0x90 enters identifier mode. A command write of any value other than 0x90 and 0x98 (0xFF included) enters array mode. In array mode a read returns `arrayData` unchanged.
- R3: A command write of 0x98 enters query mode. In query mode every read returns zero.
- R4: Read data is registered. `rdData` and a one-cycle `rdValid` pulse appear on the clock edge after the one that samples `rdStrobe`. Without a strobe, `rdData` holds its value.
- R5: In identifier mode the lookup index is the byte address shifted right by log2(BANK_W) + log2(DEV_MAX_W) - log2(DEV_W).
- R6: Only the low 8 bits of the index are decoded. Index 0 gives the manufacturer code, index 1 gives the device code, and every other index (2 and 3 included) gives zero.
- R7: When DEV_W is smaller than BANK_W, the low DEV_W bytes of the code are copied into every DEV_W-byte lane of the bank word, starting at lane 0.
- R8: `rdWidth` selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. When the access is wider than the bank, bank slice i is looked up at address + i*BANK_W and placed at byte i*BANK_W. Slices beyond the access size read zero.
- R9: When DEV_W is 0, the index is the low address byte shifted right by 1 for a 2-byte bank or by 2 for a 4-byte bank. Index 0 gives (ID code 0 << 8) | ID code 1, index 1 gives (ID code 2 << 8) | ID code 3, and any other index gives zero. The access width is ignored.
- R10: An access narrower than or equal to the bank returns the full bank-wide word in slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdWrite | input | 1 | Command byte write strobe |
| cmdData | input | 8 | Command byte |
| rdStrobe | input | 1 | Read request |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdWidth | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| arrayData | input | 32 | Array data passed through in array mode |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | Read data valid pulse |

## Verification
The bench drives three instances at once:
- a 4-byte bank of 2-byte devices;
- a 1-byte bank built from a byte-wide device that can also run 2 bytes wide;
- a 2-byte bank with the device width left unspecified.

Together they cover the shift formula, lane copying, wide-read assembly and the fallback decode on the same addresses.

The stimulus targets several ways the design could go wrong:
- Addresses above 0xFF must wrap on the low index byte. A decoder that kept the upper index bits would return zero at 0x400 and 0x404.
- A four-byte read at 0x3FE straddles a 256-entry boundary. Getting it right needs per-slice address arithmetic. A design that shifted only the base address would repeat one answer in every slice.
- Indices 2 and 3 must read zero, which catches a design that leaks lock status or the other codes.
- A hold check and mode changes through 0x98, 0x42 and 0xFF show whether reads use the wrong source or the strobe is late.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2
  } flashMode_e;

  // read strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic loadArray;
    logic loadIdent;
    logic loadZero;
  } rdCtl_t;

  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_QUERY = 8'h98;

  // log2 of a byte width restricted to 1, 2 or 4 (0 maps to 0)
  function automatic int widthLog2(input int w);
    if (w >= 4) return 2;
    else if (w >= 2) return 1;
    else return 0;
  endfunction

endpackage

// File: rtl/flash_id_ctrl.sv
module flash_id_ctrl
  import flash_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdWrite,
  input  logic [7:0] cmdData,
  input  logic       rdStrobe,
  output rdCtl_t     rdCtl,
  output flashMode_e mode,
  output logic       rdValid
);

  flashMode_e modeNext;

  always_comb begin
    modeNext = mode;
    if (cmdWrite) begin
      unique case (cmdData)
        CMD_IDENT: modeNext = MODE_IDENT;
        CMD_QUERY: modeNext = MODE_QUERY;
        default:   modeNext = MODE_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_ARRAY;
      rdValid <= 1'b0;
    end else begin
      mode    <= modeNext;
      rdValid <= rdStrobe;
    end
  end

  // a read issued alongside a command write uses the mode already in force
  always_comb begin
    rdCtl = '0;
    if (rdStrobe) begin
      unique case (mode)
        MODE_IDENT: rdCtl.loadIdent = 1'b1;
        MODE_QUERY: rdCtl.loadZero  = 1'b1;
        default:    rdCtl.loadArray = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/flash_id_lookup.sv
module flash_id_lookup
  import flash_id_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 4,
  parameter int DEV_W     = 2,
  parameter int DEV_MAX_W = 2,
  parameter logic [15:0] MFR_CODE = 16'h0089,
  parameter logic [15:0] DEV_CODE = 16'h0018
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [BANK_W*8-1:0] word
);

  localparam int SHIFT    = widthLog2(BANK_W) + widthLog2(DEV_MAX_W) - widthLog2(DEV_W);
  localparam int DEV_BITS = DEV_W * 8;
  localparam int LANES    = BANK_W / DEV_W;

  logic [7:0]  idxLow;
  logic [31:0] code;

  assign idxLow = 8'(addr >> SHIFT);

  always_comb begin
    unique case (idxLow)
      8'd0:    code = {16'h0000, MFR_CODE};
      8'd1:    code = {16'h0000, DEV_CODE};
      default: code = '0;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word[l*DEV_BITS +: DEV_BITS] = code[DEV_BITS-1:0];
  end

endmodule

// File: rtl/flash_id_datapath.sv
module flash_id_datapath
  import flash_id_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 4,
  parameter int BANK_W     = 4,
  parameter int DEV_W      = 2,
  parameter int DEV_MAX_W  = 2,
  parameter logic [15:0] MFR_CODE  = 16'h0089,
  parameter logic [15:0] DEV_CODE  = 16'h0018,
  parameter logic [15:0] EXT_CODE2 = 16'h0000,
  parameter logic [15:0] EXT_CODE3 = 16'h0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rdCtl_t                  rdCtl,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [1:0]              rdWidth,
  input  logic [DATA_BYTES*8-1:0] arrayData,
  output logic [DATA_BYTES*8-1:0] rdData
);

  localparam int DATA_W    = DATA_BYTES * 8;
  localparam int BANK_BITS = BANK_W * 8;
  localparam int SLICES    = DATA_BYTES / BANK_W;

  logic [DATA_W-1:0] identWord;

  if (DEV_W == 0) begin : g_fallback
    localparam int FB_SHIFT = widthLog2(BANK_W);
    logic [7:0] boff;
    assign boff = rdAddr[7:0] >> FB_SHIFT;
    always_comb begin
      unique case (boff)
        8'd0:    identWord = DATA_W'((32'(MFR_CODE) << 8) | 32'(DEV_CODE));
        8'd1:    identWord = DATA_W'((32'(EXT_CODE2) << 8) | 32'(EXT_CODE3));
        default: identWord = '0;
      endcase
    end
  end else begin : g_scaled
    logic [2:0] accBytes;
    always_comb begin
      unique case (rdWidth)
        2'd0:    accBytes = 3'd1;
        2'd1:    accBytes = 3'd2;
        default: accBytes = 3'd4;
      endcase
    end

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
      localparam int OFF = g * BANK_W;
      logic [BANK_BITS-1:0] sliceWord;
      flash_id_lookup #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
        .DEV_MAX_W(DEV_MAX_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
      ) i_lookup (
        .addr(rdAddr + ADDR_W'(OFF)),
        .word(sliceWord)
      );
      // slice 0 always answers; higher slices only inside the access size
      if (g == 0) begin : g_first
        assign identWord[BANK_BITS-1:0] = sliceWord;
      end else begin : g_more
        assign identWord[g*BANK_BITS +: BANK_BITS] =
          (int'(accBytes) > OFF) ? sliceWord : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (rdCtl.loadArray) rdData <= arrayData;
    else if (rdCtl.loadIdent) rdData <= identWord;
    else if (rdCtl.loadZero)  rdData <= '0;
  end

endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import flash_id_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 4,
  parameter int DEV_W     = 2,
  parameter int DEV_MAX_W = 2,
  parameter logic [15:0] MFR_CODE  = 16'h0089,
  parameter logic [15:0] DEV_CODE  = 16'h0018,
  parameter logic [15:0] EXT_CODE2 = 16'h0000,
  parameter logic [15:0] EXT_CODE3 = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdData,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdWidth,
  input  logic [31:0]       arrayData,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  localparam int DATA_BYTES = 4;

  rdCtl_t     rdCtl;
  flashMode_e mode;
  logic       isArray, isIdent, isQuery;

  assign isArray = (mode == MODE_ARRAY);
  assign isIdent = (mode == MODE_IDENT);
  assign isQuery = (mode == MODE_QUERY);

  flash_id_ctrl i_ctrl (
    .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .rdStrobe(rdStrobe), .rdCtl(rdCtl), .mode(mode), .rdValid(rdValid)
  );

  flash_id_datapath #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .BANK_W(BANK_W), .DEV_W(DEV_W),
    .DEV_MAX_W(DEV_MAX_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
    .EXT_CODE2(EXT_CODE2), .EXT_CODE3(EXT_CODE3)
  ) i_datapath (
    .clk(clk), .rst(rst), .rdCtl(rdCtl), .rdAddr(rdAddr), .rdWidth(rdWidth),
    .arrayData(arrayData), .rdData(rdData)
  );

endmodule

// File: rtl/flash_id_checker.sv
module flash_id_checker (
  input logic        clk,
  input logic        rst,
  input logic        cmdWrite,
  input logic [7:0]  cmdData,
  input logic        rdStrobe,
  input logic [31:0] arrayData,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        isArray,
  input logic        isIdent,
  input logic        isQuery
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !rdValid && rdData == 32'd0);

  // R4
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rdStrobe |=> rdValid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdStrobe |=> !rdValid && $stable(rdData));

  // R2
  ident_entry_chk: assert property (@(posedge clk) disable iff (rst)
    cmdWrite && cmdData == 8'h90 |=> isIdent);

  // R2
  array_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rdStrobe && isArray |=> rdData == $past(arrayData));

  // R3
  query_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdStrobe && isQuery |=> rdData == 32'd0);

endmodule

bind flash_id_responder flash_id_checker i_checker (
  .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdData(cmdData),
  .rdStrobe(rdStrobe), .arrayData(arrayData), .rdData(rdData),
  .rdValid(rdValid), .isArray(isArray), .isIdent(isIdent), .isQuery(isQuery)
);

// File: tb/test_flash_id_responder.sv
`timescale 1ns/1ps
module test_flash_id_responder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdWrite = 1'b0;
  logic [7:0]  cmdData = 8'h00;
  logic        rdStrobe = 1'b0;
  logic [23:0] rdAddr = '0;
  logic [1:0]  rdWidth = 2'd2;
  logic [31:0] arrayData = 32'hDEADBEEF;
  logic [31:0] dataA, dataB, dataC;
  logic        validA, validB, validC;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // A: 4-byte bank of 2-byte devices
  flash_id_responder i_flash_id_responder (
    .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdWidth(rdWidth),
    .arrayData(arrayData), .rdData(dataA), .rdValid(validA)
  );

  // B: byte bank, 2-byte-capable device wired 1 byte wide
  flash_id_responder #(.BANK_W(1), .DEV_W(1), .DEV_MAX_W(2)) i_bankByte (
    .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdWidth(rdWidth),
    .arrayData(arrayData), .rdData(dataB), .rdValid(validB)
  );

  // C: 2-byte bank, device width unspecified
  flash_id_responder #(.BANK_W(2), .DEV_W(0), .DEV_MAX_W(2),
                       .EXT_CODE2(16'h0000), .EXT_CODE3(16'h0022)) i_bankLegacy (
    .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdWidth(rdWidth),
    .arrayData(arrayData), .rdData(dataC), .rdValid(validC)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] c);
    @(negedge clk);
    cmdWrite = 1'b1;
    cmdData  = c;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  // issue a read; on return the registered data is visible
  task automatic doRead(input logic [23:0] a, input logic [1:0] w);
    @(negedge clk);
    rdStrobe = 1'b1;
    rdAddr   = a;
    rdWidth  = w;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // {addr, width, expA, expB, expC}
  localparam int NVEC = 11;
  localparam logic [123:0] VEC [NVEC] = '{
    {24'h000000, 2'd2, 32'h00890089, 32'h18188989, 32'h00008918, 2'b00},
    {24'h000004, 2'd2, 32'h00180018, 32'h00000000, 32'h00000000, 2'b00},
    {24'h000002, 2'd2, 32'h00890089, 32'h00001818, 32'h00000022, 2'b00},
    {24'h000001, 2'd0, 32'h00890089, 32'h00000089, 32'h00008918, 2'b00},
    {24'h000002, 2'd1, 32'h00890089, 32'h00001818, 32'h00000022, 2'b00},
    {24'h000400, 2'd2, 32'h00890089, 32'h18188989, 32'h00008918, 2'b00},
    {24'h000404, 2'd2, 32'h00180018, 32'h00000000, 32'h00000000, 2'b00},
    {24'h000008, 2'd2, 32'h00000000, 32'h00000000, 32'h00000000, 2'b00},
    {24'h00000C, 2'd2, 32'h00000000, 32'h00000000, 32'h00000000, 2'b00},
    {24'h0003FE, 2'd2, 32'h00000000, 32'h89890000, 32'h00000000, 2'b00},
    {24'h000006, 2'd3, 32'h00180018, 32'h00000000, 32'h00000000, 2'b00}
  };

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset rdData", dataA, 32'h0);
    check("R1 reset rdValid", {31'd0, validA}, 32'd0);

    // R2 / R1: array mode after reset passes data through
    doRead(24'h10, 2'd2);
    check("R2 array pass after reset", dataA, 32'hDEADBEEF);

    // R4: valid pulse timing
    @(negedge clk);
    rdStrobe = 1'b1;
    rdAddr   = 24'h0;
    check("R4 no valid in strobe cycle", {31'd0, validA}, 32'd0);
    @(negedge clk);
    rdStrobe = 1'b0;
    check("R4 valid one cycle later", {31'd0, validA}, 32'd1);
    @(negedge clk);
    check("R4 valid is one pulse", {31'd0, validA}, 32'd0);

    sendCmd(8'h90);
    for (int i = 0; i < NVEC; i++) begin
      doRead(VEC[i][123:100], VEC[i][99:98]);
      // R5 R6 R7 R10: scaled lookup in wide bank
      check($sformatf("R5 R6 R7 R10 bankA vec%0d", i), dataA, VEC[i][97:66]);
      // R8: wide read assembled from byte slices
      check($sformatf("R8 bankB vec%0d", i), dataB, VEC[i][65:34]);
      // R9: legacy decode
      check($sformatf("R9 bankC vec%0d", i), dataC, VEC[i][33:2]);
    end

    // R4: hold without strobe while array input changes
    arrayData = 32'h12345678;
    repeat (3) @(negedge clk);
    check("R4 hold without strobe", dataA, 32'h00180018);

    // R3: query mode reads zero
    sendCmd(8'h98);
    doRead(24'h0, 2'd2);
    check("R3 query reads zero", dataA, 32'h0);
    check("R3 query reads zero bankB", dataB, 32'h0);

    // R2: unknown command returns to array mode
    sendCmd(8'h42);
    doRead(24'h0, 2'd2);
    check("R2 other cmd array", dataA, 32'h12345678);

    // R2: 0xFF leaves identifier mode
    sendCmd(8'h90);
    doRead(24'h4, 2'd2);
    check("R2 ident re-entered", dataA, 32'h00180018);
    sendCmd(8'hFF);
    arrayData = 32'hCAFEF00D;
    doRead(24'h4, 2'd2);
    check("R2 0xFF array", dataA, 32'hCAFEF00D);

    // R1: reset from identifier mode returns to array mode
    sendCmd(8'h90);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears data", dataA, 32'h0);
    arrayData = 32'h0BADC0DE;
    doRead(24'h0, 2'd2);
    check("R1 reset enters array mode", dataA, 32'h0BADC0DE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule